// File: doc/BRIEF.md
# Memory-Scanning CRC32 Engine

This block is a small bus master that computes a CRC32 over a region of memory after software starts it. Software sets a start word address, a length in words and a seed in the data register. It then writes the start bit. The engine issues one read per clock on a fixed-latency synchronous memory port and folds each returned 32-bit word into the running CRC. When the run ends, the data register holds the uncomplemented CRC. Software inverts that value itself to obtain the standard CRC32.

Four sticky flags report how a command ended: done, fail, bus error and protection error. Software clears each flag by writing 1 to it. A run can end early for four reasons: a memory error response, a start while the engine is locked, a zero length, or a region that runs past the end of the word address space. A soft-reset bit in the control register abandons a run that is in progress.

Top module: `crc_scan_engine`

## Requirements
- R1: After reset, every register reads zero, `busy` is low and `mem_req` is low.
- R2: Register select values are 0 for control, 1 for status, 2 for the start word address, 3 for the word length and 4 for data. Any other select reads zero. During a run, `mem_req` is high on `len` consecutive cycles, and `mem_addr` starts at the address register and rises by one word per cycle.
- R3: Each word returned during a run updates the data register. The update runs the word through the reflected polynomial 0xEDB88320, least significant bit first. The data register keeps no final inversion, so seed 0xFFFFFFFF and one zero word give 0xDEBB20E3.
- R4: Writing control bit 1 (start) while idle makes `busy` high. The done flag (status bit 0) rises, and `busy` falls, exactly `len`+1 clock edges after the edge that takes the start write. Status bit 4 mirrors `busy`.
- R5: Status bits 0 to 3 are done, fail, bus error and protection error. Writing 1 to a bit clears it, writing 0 leaves it, and all four can be cleared in one write. When a flag is set and cleared on the same edge, the set wins.
- R6: A response with `mem_err` high during a run sets bus error (bit 2) and done, ends the run on that edge and stops further requests. The CRC keeps only the words that came before the error.
- R7: A start while `locked` is high sets protection error (bit 3) and done, issues no memory request and leaves the data register unchanged.
- R8: A start with length zero sets done on the next edge, issues no request and leaves the data register unchanged.
- R9: A start whose region passes the last word of the address space sets fail (bit 1) and done and issues no request. A region that ends exactly on the last word runs normally.
- R10: Control bit 0 (soft reset) ends a run at once without setting any flag. When it is written together with start, no run begins.
- R11: While `busy` is high, writes to the address, length and data registers and further starts have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selected for the write |
| reg_wdata | input | 32 | Register write data |
| rd_sel | input | 3 | Register selected for reading |
| rd_data | output | 32 | Read data, combinational on `rd_sel` |
| locked | input | 1 | Engine locked against starts |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Word address of the request |
| mem_valid | input | 1 | Response for the request of the previous cycle |
| mem_err | input | 1 | Error qualifier of the response |
| mem_rdata | input | 32 | Response data word |
| busy | output | 1 | Run in progress |

## Verification
The first memory request appears in the cycle after the edge that takes the start write. Each response arrives one cycle after its request. The done flag is therefore due on edge `len`+1, and the bench checks `busy` just before that edge and the flag just after it. The early endings (lock, zero length, overflow) show their flag one edge after the start write. A bus error shows one edge after the failing response, and a soft reset clears `busy` on the next edge. A behavioural model in the bench advances on the same edges and is compared on every falling edge plus a small delay, so each expected value is read in the cycle where it becomes due.

// File: rtl/crc_scan_engine.sv
module crc_scan_engine #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic [2:0]    rd_sel,
  output logic [31:0]   rd_data,
  input  logic          locked,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          busy
);
  localparam int LW = AW + 1;
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_STAT = 3'd1, SEL_ADDR = 3'd2,
                         SEL_LEN = 3'd3, SEL_DATA = 3'd4;
  localparam logic [31:0] POLY = 32'hEDB88320;
  localparam logic [AW+1:0] SPACE_END = {2'b01, {AW{1'b0}}};

  logic [AW-1:0] base_q, ptr_q;
  logic [LW-1:0] len_q, req_left, rsp_left;
  logic [31:0]   data_q;
  logic [3:0]    flags_q, flag_set, flag_clr;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? POLY : 32'h0);
    return r;
  endfunction

  wire ctrl_wr  = reg_we && reg_sel == SEL_CTRL;
  wire abort    = ctrl_wr && reg_wdata[0];
  wire start_w  = ctrl_wr && reg_wdata[1] && !reg_wdata[0] && !busy;
  wire len_zero = len_q == '0;
  wire [AW+1:0] region_end = (AW+2)'(base_q) + (AW+2)'(len_q);
  wire overflow = region_end > SPACE_END;
  wire start_go = start_w && !locked && !len_zero && !overflow;
  wire rsp_hit  = busy && mem_valid;
  wire idle_wr  = reg_we && !busy;

  assign busy     = rsp_left != '0;
  assign mem_req  = busy && req_left != '0;
  assign mem_addr = ptr_q;

  assign flag_set[0] = !abort && ((start_w && (locked || len_zero || overflow)) ||
                                  (rsp_hit && (mem_err || rsp_left == LW'(1))));
  assign flag_set[1] = !abort && start_w && !locked && !len_zero && overflow;
  assign flag_set[2] = !abort && rsp_hit && mem_err;
  assign flag_set[3] = !abort && start_w && locked;
  assign flag_clr    = (reg_we && reg_sel == SEL_STAT) ? reg_wdata[3:0] : 4'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      len_q    <= '0;
      data_q   <= '0;
      flags_q  <= '0;
      ptr_q    <= '0;
      req_left <= '0;
      rsp_left <= '0;
    end else begin
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      if (idle_wr && reg_sel == SEL_ADDR) base_q <= reg_wdata[AW-1:0];
      if (idle_wr && reg_sel == SEL_LEN)  len_q  <= reg_wdata[LW-1:0];
      if (idle_wr && reg_sel == SEL_DATA)
        data_q <= reg_wdata;
      else if (rsp_hit && !mem_err && !abort)
        data_q <= crc_step(data_q, mem_rdata);
      if (abort) begin
        req_left <= '0;
        rsp_left <= '0;
      end else if (start_go) begin
        req_left <= len_q;
        rsp_left <= len_q;
        ptr_q    <= base_q;
      end else if (busy) begin
        if (mem_req) ptr_q <= ptr_q + 1'b1;
        if (rsp_hit && mem_err) begin
          req_left <= '0;
          rsp_left <= '0;
        end else begin
          if (mem_req) req_left <= req_left - 1'b1;
          if (rsp_hit) rsp_left <= rsp_left - 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_STAT: rd_data = {27'h0, busy, flags_q};
      SEL_ADDR: rd_data = 32'(base_q);
      SEL_LEN:  rd_data = 32'(len_q);
      SEL_DATA: rd_data = data_q;
      default:  rd_data = 32'h0;
    endcase
  end

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + 1'b1);
  assert_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flags_q[0] || $past(abort));
  assert_clear_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_sel == SEL_STAT && reg_wdata[0] && !busy |=> !flags_q[0]);
  assert_err_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit && mem_err && !abort |=> !busy && !mem_req && flags_q[2] && flags_q[0]);
  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_w && locked |=> flags_q[3] && flags_q[0] && !busy);
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_w && !locked && len_q == '0 |=> flags_q[0] && !mem_req);
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !mem_req);
endmodule

// File: tb/tb_crc_scan_engine.sv
module tb_crc_scan_engine;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, locked = 0;
  logic [2:0] reg_sel = 0, rd_sel = 3'd4;
  logic [31:0] reg_wdata = 0, rd_data, mem_rdata = 0;
  logic mem_req, mem_valid = 0, mem_err = 0, busy;
  logic [AW-1:0] mem_addr;
  logic err_en = 0;
  logic [AW-1:0] err_at = 0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  crc_scan_engine #(.AW(AW)) dut (.*);

  function automatic logic [31:0] word_at(input logic [AW-1:0] a);
    return (a == 16) ? 32'h0 : (32'(a) * 32'h9E3779B1) ^ 32'h5A5AA5A5;
  endfunction

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 32; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    mem_valid <= rst_n && mem_req;
    mem_rdata <= word_at(mem_addr);
    mem_err   <= rst_n && mem_req && err_en && mem_addr == err_at;
  end

  int m_base, m_len, m_ptr, m_rq, m_rsp;
  logic [31:0] m_data;
  logic [3:0] m_flags, m_set;
  logic m_busy;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_len = 0; m_ptr = 0; m_rq = 0; m_rsp = 0; m_data = 0; m_flags = 0;
    end else begin
      m_busy = m_rsp != 0;
      m_set = 0;
      if (reg_we && reg_sel == 1) m_flags = m_flags & ~reg_wdata[3:0];
      if (reg_we && reg_sel == 0 && reg_wdata[0]) begin
        m_rq = 0; m_rsp = 0;
      end else begin
        if (m_busy) begin
          if (m_rq != 0) begin m_ptr++; m_rq--; end
          if (mem_valid && mem_err) begin m_set = 4'b0101; m_rq = 0; m_rsp = 0; end
          else if (mem_valid) begin
            m_data = crc_ref(m_data, mem_rdata);
            m_rsp--;
            if (m_rsp == 0) m_set = 4'b0001;
          end
        end else if (reg_we && reg_sel == 0 && reg_wdata[1]) begin
          if (locked) m_set = 4'b1001;
          else if (m_len == 0) m_set = 4'b0001;
          else if (m_base + m_len > (1 << AW)) m_set = 4'b0011;
          else begin m_rq = m_len; m_rsp = m_len; m_ptr = m_base; end
        end
      end
      if (reg_we && !m_busy) begin
        if (reg_sel == 2) m_base = int'(reg_wdata[AW-1:0]);
        if (reg_sel == 3) m_len = int'(reg_wdata[AW:0]);
        if (reg_sel == 4) m_data = reg_wdata;
      end
      m_flags = m_flags | m_set;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] s);
    case (s)
      3'd1: return {27'h0, m_rsp != 0, m_flags};
      3'd2: return 32'(m_base);
      3'd3: return 32'(m_len);
      3'd4: return m_data;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2 mem_req", 32'(mem_req), 32'(m_rsp != 0 && m_rq != 0));
      if (mem_req) chk("R2 mem_addr", 32'(mem_addr), 32'(m_ptr));
      chk("R4 busy", 32'(busy), 32'(m_rsp != 0));
      chk("R3 register read", rd_data, exp_rd(rd_sel));
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    rd_sel = s;
    #1 v = rd_data;
    rd_sel = 3'd4;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset req", 32'(mem_req), 0);

    wr(4, 32'hFFFFFFFF); wr(2, 16); wr(3, 1); wr(0, 2);
    wait_idle(); #1;
    rd(4, v); chk("R3 zero word crc", v, 32'hDEBB20E3);
    rd(1, v); chk("R4 done after run", v, 32'h1);
    wr(1, 0); rd(1, v); chk("R5 write 0 keeps done", v, 32'h1);
    wr(1, 1); rd(1, v); chk("R5 write 1 clears done", v, 32'h0);

    wr(4, 32'hFFFFFFFF); wr(2, 100); wr(3, 20); wr(0, 2);
    repeat (20) @(negedge clk);
    #1 chk("R4 busy before last edge", 32'(busy), 1);
    @(negedge clk);
    #1 chk("R4 idle on edge len+1", 32'(busy), 0);
    rd(1, v); chk("R4 done on edge len+1", v, 32'h1);
    rd(4, v); chk("R3 crc of 20 words", v, m_data);
    wr(1, 32'hF);

    err_en = 1; err_at = 205;
    wr(4, 32'h12345678); wr(2, 200); wr(3, 10); wr(0, 2);
    wait_idle(); #1;
    rd(1, v); chk("R6 bus error and done", v, 32'h5);
    keep = 32'h12345678;
    for (int a = 200; a < 205; a++) keep = crc_ref(keep, word_at(16'(a)));
    rd(4, v); chk("R6 crc before error", v, keep);
    err_en = 0;
    wr(1, 32'hF); rd(1, v); chk("R5 clear all flags", v, 32'h0);

    rd(4, keep);
    locked = 1; wr(0, 2); locked = 0;
    rd(1, v); chk("R7 protection error", v, 32'h9);
    rd(4, v); chk("R7 data unchanged", v, keep);
    wr(1, 32'hF);

    wr(3, 0); wr(0, 2);
    rd(1, v); chk("R8 zero length done", v, 32'h1);
    rd(4, v); chk("R8 data unchanged", v, keep);
    wr(1, 32'hF);

    wr(2, 32'hFFFE); wr(3, 3); wr(0, 2);
    rd(1, v); chk("R9 overflow fail", v, 32'h3);
    wr(1, 32'hF);
    wr(3, 2); wr(0, 2);
    wait_idle(); #1;
    rd(1, v); chk("R9 region at end runs", v, 32'h1);
    wr(1, 32'hF);

    wr(2, 300); wr(3, 40); wr(0, 2);
    repeat (5) @(negedge clk);
    wr(0, 1);
    #1 chk("R10 abort clears busy", 32'(busy), 0);
    rd(1, v); chk("R10 abort sets no flag", v, 32'h0);
    wr(0, 3);
    #1 chk("R10 start with reset idle", 32'(busy), 0);

    wr(2, 400); wr(3, 8); wr(4, 32'hFFFFFFFF); wr(0, 2);
    wr(2, 7); wr(3, 2); wr(4, 32'hDEADBEEF); wr(0, 2);
    wait_idle(); #1;
    rd(2, v); chk("R11 address ignored", v, 32'd400);
    rd(3, v); chk("R11 length ignored", v, 32'd8);
    keep = 32'hFFFFFFFF;
    for (int a = 400; a < 408; a++) keep = crc_ref(keep, word_at(16'(a)));
    rd(4, v); chk("R11 data write ignored", v, keep);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule